// File: doc/BRIEF.md
# Panel Sync and Window Timing Generator

This block produces the raster timing for a flat panel on the panel pixel clock. A horizontal counter steps through the pixel clocks of each line, and a vertical counter steps through the lines of each frame. The block decodes both counters into active-high sync pulses, a display-enable (DE) region and a smaller image region that sits inside DE. Downstream logic fills the band between the two regions with a border.

Every position, width and total is a static configuration input, normally driven from a register file outside this block. When a total is programmed to its all-ones value, that counter stops wrapping on its own. It then follows external line and frame strobes, which allows the panel timing to be slaved to an incoming video source. The counters are presented at the ports so that other logic can use the raster position.

Top module: `panel_timing_gen`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, h_count and v_count are 0.
- R2: With h_total not equal to 0xFFF, h_count advances by one each clock and goes from h_total-1 to 0.
- R3: v_count changes only at a line end, which is a natural horizontal wrap or an ext_line_strobe. With v_total not equal to 0x7FF, it goes from v_total-1 to 0 at a line end. Otherwise it advances by one at a line end.
- R4: hsync is 1 exactly when h_count < h_sync_width, so a width of 0 gives no pulse.
- R5: vsync is 1 exactly when v_count < v_sync_width.
- R6: de is 1 exactly when h_de_start <= h_count < h_de_end and v_de_start <= v_count < v_de_end.
- R7: img_active is 1 exactly when h_count lies in [h_img_start, h_img_end), v_count lies in [v_img_start, v_img_end) and de is 1. Image ranges that extend past DE are clipped to DE.
- R8: With h_total = 0xFFF, h_count never wraps by itself: it holds at 0xFFF, and no line end occurs without a strobe.
- R9: With v_total = 0x7FF, v_count holds at 0x7FF once it reaches that value.
- R10: ext_line_strobe high at a clock edge sets h_count to 0 and counts as a line end. ext_frame_strobe high sets v_count to 0, and this takes priority over any line advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Panel pixel clock |
| rst_n | input | 1 | Active-low reset |
| h_total | input | 12 | Pixel clocks per line; 0xFFF selects external line lock |
| h_sync_width | input | 8 | hsync width in pixel clocks |
| h_de_start | input | 12 | First DE pixel position |
| h_de_end | input | 12 | Position one past the last DE pixel |
| h_img_start | input | 12 | First image pixel position |
| h_img_end | input | 12 | Position one past the last image pixel |
| v_total | input | 11 | Lines per frame; 0x7FF selects external frame lock |
| v_sync_width | input | 8 | vsync width in lines |
| v_de_start | input | 11 | First DE line |
| v_de_end | input | 11 | Line one past the last DE line |
| v_img_start | input | 11 | First image line |
| v_img_end | input | 11 | Line one past the last image line |
| ext_line_strobe | input | 1 | External line start: clears h_count |
| ext_frame_strobe | input | 1 | External frame start: clears v_count |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| img_active | output | 1 | Image region inside DE |
| h_count | output | 12 | Current pixel position |
| v_count | output | 11 | Current line |

## Verification
The locked modes are the hardest to reach from the ports. The horizontal counter only shows its saturation after more than four thousand cycles without a strobe. The vertical counter only shows it after two thousand lines. The bench therefore runs those long stretches with short horizontal lines, then pulses each strobe, including both strobes in the same cycle, and checks that the counters clear and that the frame strobe takes priority. A second configuration places the image ranges beyond DE and sets the hsync width to zero, which exercises the clipping and empty-pulse cases.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int H_W  = 12;
    localparam int V_W  = 11;
    localparam int SW_W = 8;

    // Power-on register values used by the surrounding register file.
    localparam logic [H_W-1:0]  DEF_H_DE_START = 12'h128;
    localparam logic [H_W-1:0]  DEF_H_DE_END   = 12'h528;
    localparam logic [H_W-1:0]  DEF_H_TOTAL    = 12'h540;
    localparam logic [SW_W-1:0] DEF_H_SYNC_W   = 8'h88;
    localparam logic [SW_W-1:0] DEF_V_SYNC_W   = 8'h06;
    localparam logic [V_W-1:0]  DEF_V_DE_START = 11'h023;
    localparam logic [V_W-1:0]  DEF_V_DE_END   = 11'h323;
    localparam logic [V_W-1:0]  DEF_V_TOTAL    = 11'h326;
endpackage

// File: rtl/ptg_axis_counter.sv
module ptg_axis_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         clear,
    input  logic [W-1:0] total,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;
    logic   locked, at_end, at_max;

    always_comb begin
        locked = (total == ALL_ONES);
        at_end = !locked && (st_q.cnt == total - 1'b1);
        at_max = (st_q.cnt == ALL_ONES);
        st_d   = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (advance) begin
            if (at_end)       st_d.cnt = '0;
            else if (!at_max) st_d.cnt = st_q.cnt + 1'b1;
        end
        wrap = advance && at_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R2 / R3: natural wrap returns to zero
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && total != ALL_ONES && cnt == total - 1'b1) |=> (cnt == '0));
    // R3: no change without an advance or clear
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !clear) |=> $stable(cnt));
    // R8 / R9: locked counter saturates
    a_r8_locked_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (total == ALL_ONES && cnt == ALL_ONES && !clear) |=> (cnt == ALL_ONES));
    // R10: clear always wins
    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0));
endmodule

// File: rtl/ptg_window.sv
module ptg_window #(
    parameter int W  = 12,
    parameter int SW = 8
) (
    input  logic [W-1:0]  cnt,
    input  logic [SW-1:0] sync_w,
    input  logic [W-1:0]  de_start,
    input  logic [W-1:0]  de_end,
    input  logic [W-1:0]  img_start,
    input  logic [W-1:0]  img_end,
    output logic          sync,
    output logic          de_win,
    output logic          img_win
);
    localparam int PAD = W - SW;

    always_comb begin
        sync    = cnt < {{PAD{1'b0}}, sync_w};
        de_win  = (cnt >= de_start)  && (cnt < de_end);
        img_win = (cnt >= img_start) && (cnt < img_end);
    end
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [H_W-1:0]  h_total,
    input  logic [SW_W-1:0] h_sync_width,
    input  logic [H_W-1:0]  h_de_start,
    input  logic [H_W-1:0]  h_de_end,
    input  logic [H_W-1:0]  h_img_start,
    input  logic [H_W-1:0]  h_img_end,
    input  logic [V_W-1:0]  v_total,
    input  logic [SW_W-1:0] v_sync_width,
    input  logic [V_W-1:0]  v_de_start,
    input  logic [V_W-1:0]  v_de_end,
    input  logic [V_W-1:0]  v_img_start,
    input  logic [V_W-1:0]  v_img_end,
    input  logic            ext_line_strobe,
    input  logic            ext_frame_strobe,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic            img_active,
    output logic [H_W-1:0]  h_count,
    output logic [V_W-1:0]  v_count
);
    logic h_wrap, v_wrap, line_end;
    logic h_de, v_de, h_img, v_img;

    assign line_end = ext_line_strobe || h_wrap;

    ptg_axis_counter #(.W(H_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .advance(1'b1), .clear(ext_line_strobe),
        .total(h_total), .cnt(h_count), .wrap(h_wrap)
    );

    ptg_axis_counter #(.W(V_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .advance(line_end), .clear(ext_frame_strobe),
        .total(v_total), .cnt(v_count), .wrap(v_wrap)
    );

    ptg_window #(.W(H_W), .SW(SW_W)) u_hwin (
        .cnt(h_count), .sync_w(h_sync_width), .de_start(h_de_start), .de_end(h_de_end),
        .img_start(h_img_start), .img_end(h_img_end),
        .sync(hsync), .de_win(h_de), .img_win(h_img)
    );

    ptg_window #(.W(V_W), .SW(SW_W)) u_vwin (
        .cnt(v_count), .sync_w(v_sync_width), .de_start(v_de_start), .de_end(v_de_end),
        .img_start(v_img_start), .img_end(v_img_end),
        .sync(vsync), .de_win(v_de), .img_win(v_img)
    );

    always_comb begin
        de         = h_de && v_de;
        img_active = h_img && v_img && de;
    end

    // R7: image never outside DE
    a_r7_img_inside_de: assert property (@(posedge clk) disable iff (!rst_n)
        img_active |-> (h_de && v_de));
    // R3: frame wrap only at a line end
    a_r3_vwrap_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        v_wrap |-> line_end);
    // R8: locked line never ends by itself
    a_r8_no_self_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        (h_total == '1) |-> !h_wrap);
endmodule

// File: tb/panel_timing_gen_tb.sv
module panel_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] h_total, h_de_start, h_de_end, h_img_start, h_img_end;
    logic [7:0]  h_sync_width, v_sync_width;
    logic [10:0] v_total, v_de_start, v_de_end, v_img_start, v_img_end;
    logic        ext_line_strobe = 1'b0, ext_frame_strobe = 1'b0;
    logic        hsync, vsync, de, img_active;
    logic [11:0] h_count;
    logic [10:0] v_count;

    int checks = 0;
    int errors = 0;
    int mh = 0;
    int mv = 0;

    always #4 clk = ~clk;

    panel_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_total(h_total), .h_sync_width(h_sync_width),
        .h_de_start(h_de_start), .h_de_end(h_de_end),
        .h_img_start(h_img_start), .h_img_end(h_img_end),
        .v_total(v_total), .v_sync_width(v_sync_width),
        .v_de_start(v_de_start), .v_de_end(v_de_end),
        .v_img_start(v_img_start), .v_img_end(v_img_end),
        .ext_line_strobe(ext_line_strobe), .ext_frame_strobe(ext_frame_strobe),
        .hsync(hsync), .vsync(vsync), .de(de), .img_active(img_active),
        .h_count(h_count), .v_count(v_count)
    );

    // Expected raster position, derived from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            mh <= 0;
            mv <= 0;
        end else begin
            bit hend, lend;
            hend = (h_total != 12'hFFF) && (mh == int'(h_total) - 1);
            lend = ext_line_strobe || hend;
            if (ext_line_strobe)  mh <= 0;
            else if (hend)        mh <= 0;
            else if (mh != 4095)  mh <= mh + 1;
            if (ext_frame_strobe) mv <= 0;
            else if (lend) begin
                if ((v_total != 11'h7FF) && (mv == int'(v_total) - 1)) mv <= 0;
                else if (mv != 2047) mv <= mv + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic check_all();
        bit ed, ei;
        ed = (mh >= int'(h_de_start)) && (mh < int'(h_de_end)) &&
             (mv >= int'(v_de_start)) && (mv < int'(v_de_end));
        ei = ed && (mh >= int'(h_img_start)) && (mh < int'(h_img_end)) &&
             (mv >= int'(v_img_start)) && (mv < int'(v_img_end));
        check("R2 h_count", int'(h_count), mh);
        check("R3 v_count", int'(v_count), mv);
        check("R4 hsync", int'(hsync), int'(mh < int'(h_sync_width)));
        check("R5 vsync", int'(vsync), int'(mv < int'(v_sync_width)));
        check("R6 de", int'(de), int'(ed));
        check("R7 img_active", int'(img_active), int'(ei));
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic cfg_a();
        h_total = 12'd16; h_sync_width = 8'd3;
        h_de_start = 12'd2; h_de_end = 12'd12; h_img_start = 12'd4; h_img_end = 12'd10;
        v_total = 11'd6; v_sync_width = 8'd1;
        v_de_start = 11'd1; v_de_end = 11'd5; v_img_start = 11'd2; v_img_end = 11'd4;
    endtask

    task automatic test_reset();
        cfg_a();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 h_count in reset", int'(h_count), 0);
        check("R1 v_count in reset", int'(v_count), 0);
        rst_n = 1'b1;
        check_all();
        run(1);
        check("R1 h_count after reset", int'(h_count), 1);
    endtask

    task automatic test_normal_frames();
        run(16 * 6 * 2 + 5);
    endtask

    task automatic test_clipped_image();
        h_sync_width = 8'd0; v_sync_width = 8'd2;
        h_img_start = 12'd0; h_img_end = 12'd15;
        v_img_start = 11'd0; v_img_end = 11'd6;
        run(16 * 6 * 2);
        cfg_a();
    endtask

    task automatic test_mid_line_strobe();
        run(5);
        ext_line_strobe = 1'b1;
        run(1);
        ext_line_strobe = 1'b0;
        check("R10 line strobe clears h", int'(h_count), 0);
        run(20);
        ext_frame_strobe = 1'b1;
        run(1);
        ext_frame_strobe = 1'b0;
        check("R10 frame strobe clears v", int'(v_count), 0);
        run(30);
    endtask

    task automatic test_h_lock();
        h_total = 12'hFFF;
        run(4200);
        check("R8 h held at max", int'(h_count), 4095);
        ext_line_strobe = 1'b1;
        run(1);
        ext_line_strobe = 1'b0;
        check("R8 strobe restarts h", int'(h_count), 0);
        run(10);
        h_total = 12'd16;
        run(40);
    endtask

    task automatic test_v_lock();
        v_total = 11'h7FF;
        run(16 * 2100);
        check("R9 v held at max", int'(v_count), 2047);
        run(16);
        ext_line_strobe = 1'b1;
        ext_frame_strobe = 1'b1;
        run(1);
        ext_line_strobe = 1'b0;
        ext_frame_strobe = 1'b0;
        check("R10 frame strobe priority", int'(v_count), 0);
        check("R10 line strobe with frame", int'(h_count), 0);
        run(40);
        v_total = 11'd6;
        run(200);
    endtask

    initial begin
        test_reset();
        test_normal_frames();
        test_clipped_image();
        test_mid_line_strobe();
        test_h_lock();
        test_v_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule